// File: doc/BRIEF.md
# Consecutive-Sample Comparator Output Filter

This block cleans up the one-bit output of an analog comparator that has already been brought into the digital domain. It removes short noise spikes, such as the fast chatter a comparator produces when its two inputs sit within its offset voltage of each other. The raw level first passes through a two-flop synchronizer. It is then sampled at discrete instants. The filtered output flips only after a programmable number of back-to-back samples all disagree with it.

Sampling instants come from one of two sources, chosen by `ext_sel`. The first is an internal divider that fires once every `period_val` clock cycles. The second is the rising edge of an external strobe, which is synchronized and edge-detected in the clock domain. The filter runs only when the count setting is at least 2 and a sampling source exists. Otherwise it stays in a cleared state with a low output. The count, period and source settings are captured when the filter enters the running state. Changing them later requires a pass through the cleared state.

Top module: `cmp_glitch_filter`

## Requirements
- R1: The filter runs only when `count_val` > 1 and (`period_val` != 0 or `ext_sel` = 1). In any other setting, `filt_out` is 0 from the next clock edge on, whatever `raw_in` does.
- R2: With `ext_sel` = 0, the synchronized raw level is sampled once every `period_val` clock cycles. Starting just after a sample-driven flip, with `raw_in` changed to the opposite level at once and `period_val` >= 3, the next flip comes exactly `count_val` x `period_val` clock edges later.
- R3: With `ext_sel` = 1, exactly one sample is taken per rising edge of `strobe_in`. Holding the strobe high adds no further samples.
- R4: `filt_out` changes only when `count_val` consecutive samples all differ from its present value.
- R5: `filt_out` is 0 when the filter starts, even if `raw_in` is high. In divided-clock mode with `raw_in` steadily high, call the first clock edge that sees the enabling settings edge 1. `filt_out` first reads 1 after edge `count_val` x `period_val` + 1.
- R6: When the settings leave the running state while `filt_out` is 1, `filt_out` reads 0 after the next clock edge, and the filter restarts from its cleared state.
- R7: A sample equal to the present output restarts the consecutive count. Disagreeing samples that are separated by an agreeing one never cause a flip.
- R8: `count_val`, `period_val` and `ext_sel` are captured on entry to the running state. Changes made while running that keep the enable rule true have no effect until the filter has passed through the cleared state.
- R9: `filt_chg` is a one-cycle pulse, aligned with the cycle in which a sample-driven flip of `filt_out` first becomes visible.
- R10: Synchronous reset drives `filt_out` and `filt_chg` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 1 | Raw comparator level (asynchronous) |
| strobe_in | input | 1 | External sample strobe (asynchronous) |
| ext_sel | input | 1 | 1: sample on strobe edges, 0: internal divider |
| period_val | input | 8 | Divider period in clock cycles |
| count_val | input | 3 | Consecutive disagreeing samples needed to flip |
| filt_out | output | 1 | Filtered comparator level |
| filt_chg | output | 1 | One-cycle pulse on each sample-driven flip |

## Verification
Each pattern is chosen to separate one behaviour from the others. A steady high level, applied to a freshly enabled filter, fixes the first-flip latency to the exact edge, so it exposes any off-by-one in the divider or the vote counter. A level that is toggled right after every flip measures the interval between flips for several count and period pairs, both before and after the settings are changed in the running state. This shows whether new settings leak in without a pass through the cleared state. Low bursts broken by a single agreeing sample show whether the count really restarts, and a strobe held high for many cycles shows whether samples are taken on edges rather than on levels.

// File: rtl/cgf_pkg.sv
package cgf_pkg;
  localparam int CGF_CNT_W = 3;
  localparam int CGF_PER_W = 8;
  localparam int CGF_SYNC_STAGES = 2;

  typedef enum logic {
    SRC_DIV = 1'b0,
    SRC_EXT = 1'b1
  } cgf_src_e;
endpackage

// File: rtl/cgf_sync.sv
module cgf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cgf_tick_gen.sv
module cgf_tick_gen
  import cgf_pkg::*;
#(
  parameter int PER_W = CGF_PER_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  cgf_src_e         src,
  input  logic [PER_W-1:0] per,
  input  logic             strobe_s,
  output logic             tick
);
  logic [PER_W-1:0] div_cnt;
  logic             strobe_d;
  logic             div_hit;
  logic             edge_hit;

  assign div_hit  = (div_cnt == per - PER_W'(1));
  assign edge_hit = strobe_s & ~strobe_d;

  always_ff @(posedge clk) begin
    if (rst || !active || src != SRC_DIV) div_cnt <= '0;
    else if (div_hit)                     div_cnt <= '0;
    else                                  div_cnt <= div_cnt + PER_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) strobe_d <= 1'b0;
    else     strobe_d <= strobe_s;
  end

  always_comb begin
    tick = 1'b0;
    if (active) tick = (src == SRC_EXT) ? edge_hit : div_hit;
  end

  a_r2_div_bound: assert property (@(posedge clk) disable iff (rst)
    (active && src == SRC_DIV) |-> (div_cnt < per));

  a_r3_one_tick_per_edge: assert property (@(posedge clk) disable iff (rst)
    (active && src == SRC_EXT && tick) |=> !tick);
endmodule

// File: rtl/cgf_vote.sv
module cgf_vote #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             tick,
  input  logic             level_s,
  input  logic [CNT_W-1:0] need,
  output logic             out_q,
  output logic             chg_q
);
  logic [CNT_W-1:0] agree;
  logic             differs;
  logic             last_one;

  assign differs  = (level_s != out_q);
  assign last_one = (agree == need - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      out_q <= 1'b0;
      chg_q <= 1'b0;
      agree <= '0;
    end else begin
      chg_q <= 1'b0;
      if (tick) begin
        if (!differs) begin
          agree <= '0;
        end else if (last_one) begin
          out_q <= ~out_q;
          chg_q <= 1'b1;
          agree <= '0;
        end else begin
          agree <= agree + CNT_W'(1);
        end
      end
    end
  end

  a_r4_flip_on_tick_only: assert property (@(posedge clk) disable iff (rst)
    ($past(active) && out_q != $past(out_q)) |-> $past(tick));

  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    active |-> (agree < need));

  a_r7_restart_on_agree: assert property (@(posedge clk) disable iff (rst)
    (active && tick && !differs) |=> (agree == '0));

  a_r6_cleared_when_off: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!out_q && agree == '0));

  a_r9_pulse_marks_flip: assert property (@(posedge clk) disable iff (rst)
    chg_q |-> (out_q != $past(out_q)));

  a_r9_pulse_single: assert property (@(posedge clk) disable iff (rst)
    chg_q |=> !chg_q);
endmodule

// File: rtl/cmp_glitch_filter.sv
module cmp_glitch_filter
  import cgf_pkg::*;
#(
  parameter int CNT_W       = CGF_CNT_W,
  parameter int PER_W       = CGF_PER_W,
  parameter int SYNC_STAGES = CGF_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw_in,
  input  logic             strobe_in,
  input  logic             ext_sel,
  input  logic [PER_W-1:0] period_val,
  input  logic [CNT_W-1:0] count_val,
  output logic             filt_out,
  output logic             filt_chg
);
  logic             en_now;
  logic             en_q;
  logic             active;
  logic [CNT_W-1:0] cfg_cnt;
  logic [PER_W-1:0] cfg_per;
  cgf_src_e         cfg_src;
  logic             raw_s;
  logic             strobe_s;
  logic             tick;

  assign en_now = (count_val > CNT_W'(1)) && ((period_val != '0) || ext_sel);
  assign active = en_q && en_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      cfg_cnt <= '0;
      cfg_per <= '0;
      cfg_src <= SRC_DIV;
    end else begin
      en_q <= en_now;
      if (!en_q) begin
        cfg_cnt <= count_val;
        cfg_per <= period_val;
        cfg_src <= ext_sel ? SRC_EXT : SRC_DIV;
      end
    end
  end

  cgf_sync #(.STAGES(SYNC_STAGES)) u_raw_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(raw_s)
  );

  cgf_sync #(.STAGES(SYNC_STAGES)) u_stb_sync (
    .clk(clk), .rst(rst), .d(strobe_in), .q(strobe_s)
  );

  cgf_tick_gen #(.PER_W(PER_W)) u_tick (
    .clk(clk), .rst(rst), .active(active), .src(cfg_src),
    .per(cfg_per), .strobe_s(strobe_s), .tick(tick)
  );

  cgf_vote #(.CNT_W(CNT_W)) u_vote (
    .clk(clk), .rst(rst), .active(active), .tick(tick),
    .level_s(raw_s), .need(cfg_cnt), .out_q(filt_out), .chg_q(filt_chg)
  );

  a_r1_low_count_forces_zero: assert property (@(posedge clk) disable iff (rst)
    (count_val <= CNT_W'(1)) |=> !filt_out);

  a_r8_cfg_held_while_running: assert property (@(posedge clk) disable iff (rst)
    $past(en_q) |-> ($stable(cfg_cnt) && $stable(cfg_per) && $stable(cfg_src)));
endmodule

// File: tb/sim_cmp_glitch_filter.sv
`timescale 1ns/1ps
module sim_cmp_glitch_filter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       raw_in = 1'b0;
  logic       strobe_in = 1'b0;
  logic       ext_sel = 1'b0;
  logic [7:0] period_val = 8'd0;
  logic [2:0] count_val = 3'd0;
  logic       filt_out;
  logic       filt_chg;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cmp_glitch_filter u0 (
    .clk(clk), .rst(rst), .raw_in(raw_in), .strobe_in(strobe_in),
    .ext_sel(ext_sel), .period_val(period_val), .count_val(count_val),
    .filt_out(filt_out), .filt_chg(filt_chg)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go_off();
    @(negedge clk);
    period_val = 8'd0; ext_sel = 1'b0; strobe_in = 1'b0;
    idle(3);
  endtask

  // Waits for a flip, reverses the raw level and counts edges to the next flip.
  task automatic measure(input int exp, input string req);
    int n = 0;
    int guard = 0;
    while (!filt_chg && guard < 600) begin @(negedge clk); guard++; end
    raw_in = ~filt_out;
    guard = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk); guard++;
    end while (!filt_chg && guard < 600);
    check(req, n, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1; raw_in = 1'b1;
    idle(4);
    check("R10 filt_out in reset", filt_out, 0);
    check("R10 filt_chg in reset", filt_chg, 0);
    rst = 1'b0;
    idle(2);
  endtask

  task automatic t_enable_rule();
    int seen = 0;
    raw_in = 1'b1; count_val = 3'd1; period_val = 8'd2; ext_sel = 1'b1;
    for (int i = 0; i < 60; i++) begin @(negedge clk); seen |= filt_out; end
    check("R1 count=1 keeps output low", seen, 0);
    count_val = 3'd2; period_val = 8'd0; ext_sel = 1'b0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); seen |= filt_out; end
    check("R1 period=0 internal mode keeps output low", seen, 0);
  endtask

  task automatic t_first_latency();
    int n = 0;
    raw_in = 1'b1;
    @(negedge clk);
    count_val = 3'd3; period_val = 8'd4; ext_sel = 1'b0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!filt_out && n < 200);
    check("R5 first rise edge count", n, 13);
  endtask

  task automatic t_glitch();
    int seen_low = 0;
    raw_in = 1'b0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); seen_low |= !filt_out; end
    raw_in = 1'b1;
    for (int i = 0; i < 4; i++) begin @(negedge clk); seen_low |= !filt_out; end
    raw_in = 1'b0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); seen_low |= !filt_out; end
    raw_in = 1'b1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); seen_low |= !filt_out; end
    check("R7 broken runs do not flip", seen_low, 0);
    raw_in = 1'b0;
    idle(24);
    check("R4 unbroken run flips low", filt_out, 0);
  endtask

  task automatic t_intervals();
    go_off();
    raw_in = 1'b1;
    count_val = 3'd4; period_val = 8'd5;
    measure(20, "R2 interval cnt4 per5");
    measure(20, "R9 interval pulse-to-pulse cnt4 per5");
    count_val = 3'd2; period_val = 8'd9;
    measure(20, "R8 live change ignored");
    go_off();
    raw_in = 1'b1;
    count_val = 3'd7; period_val = 8'd3;
    measure(21, "R2 interval cnt7 per3");
    go_off();
    raw_in = 1'b1;
    count_val = 3'd2; period_val = 8'd9;
    measure(18, "R8 new settings after off pass");
  endtask

  task automatic t_pulse_width();
    int guard = 0;
    while (!filt_chg && guard < 600) begin @(negedge clk); guard++; end
    @(negedge clk);
    check("R9 pulse lasts one cycle", filt_chg, 0);
  endtask

  task automatic pulse();
    strobe_in = 1'b1; idle(2);
    strobe_in = 1'b0; idle(4);
  endtask

  task automatic t_external();
    go_off();
    raw_in = 1'b1; count_val = 3'd3; period_val = 8'd0; ext_sel = 1'b1;
    idle(4);
    pulse(); pulse();
    check("R3 two strobe edges not enough", filt_out, 0);
    pulse();
    check("R3 third strobe edge flips", filt_out, 1);
    raw_in = 1'b0;
    idle(4);
    strobe_in = 1'b1;
    idle(40);
    check("R3 held strobe counts once", filt_out, 1);
    strobe_in = 1'b0;
    idle(4);
    pulse(); pulse();
    check("R3 two more edges complete the run", filt_out, 0);
  endtask

  task automatic t_disable();
    go_off();
    raw_in = 1'b1; count_val = 3'd2; period_val = 8'd3;
    idle(30);
    check("R6 precondition output high", filt_out, 1);
    period_val = 8'd0;
    @(negedge clk);
    check("R6 output cleared after one edge", filt_out, 0);
    idle(20);
    check("R6 stays cleared while off", filt_out, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_enable_rule();
    go_off();
    t_first_latency();
    t_glitch();
    t_intervals();
    t_pulse_width();
    t_external();
    t_disable();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule